// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block stands on the path between a single bus requester and a set of downstream peripheral ports. Every request names its target port. It also carries a read/write flag, an address, a transfer size, write data, and two attribute bits: one marks the access as coming from the secure world, the other marks it as unprivileged. For each port, configuration inputs choose which security world may reach it and whether unprivileged code may use it. A static mask parameter can exempt chosen ports from the world check.

A permitted request goes to its port one cycle after the gate accepts it, and the port's reply is handed back upstream. A refused request never leaves the gate. The gate answers it itself one cycle after acceptance. Depending on a global selection input, that answer is either an error or a quiet success: a read returns zero and a write is dropped.

Every refusal sets a sticky violation flag. The flag drives a registered interrupt through an enable input. A clear input empties the flag, and while the clear input is held high no refusal can set it.

Top module: `ppg_gate`

## Requirements
- R1: After reset all per-port world bits, all unprivileged-permit bits and the response-select state are 0, the interrupt is low and `req_ready` is high. As a result, only secure privileged accesses pass.
- R2: A request is refused when its `req_secure` bit equals the target port's `cfg_ns` bit. A `cfg_ns` bit of 1 means non-secure only, and 0 means secure only.
- R3: For every port whose bit in parameter `SEC_BYPASS` is 1, the world check of R2 is skipped. The privilege check of R4 still applies to that port.
- R4: A request with `req_user` = 1 to a port whose `cfg_upriv` bit is 0 is refused, whatever its world.
- R5: A refused request raises no `dn_valid`. If response-select was 1 when the request was accepted, the answer has `rsp_err` = 1.
- R6: A refused request raises no `dn_valid`. If response-select was 0 when the request was accepted, the answer has `rsp_err` = 0, and a refused read returns `rsp_rdata` = 0.
- R7: `irq` is a register equal to violation status AND `irq_en`. A refusal shows on `irq` in the cycle after its acceptance edge, provided `irq_en` was high at that edge.
- R8: At any edge where `irq_clr` is high, the violation status becomes 0. A refusal accepted at such an edge does not set the status.
- R9: `req_ready` is high only when no transaction is outstanding. A permitted request drives the one-hot `dn_valid` bit of its port in the cycle after acceptance, holds it until the matching `dn_ready`, and then returns the first `dn_rvalid` of that port upstream as `rsp_valid`.
- R10: The answer to a refused request is a one-cycle `rsp_valid` pulse in the cycle right after its acceptance edge.
- R11: `req_size` 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes, which must be naturally aligned. Lanes are little-endian. `dn_strb` has bits offset to offset+n-1 set, where the offset is `req_addr[2:0]`. Write byte i appears on lane offset+i. Read byte i of `rsp_rdata` is taken from lane offset+i, and the bytes above the size are 0.
- R12: The configuration inputs `cfg_ns`, `cfg_upriv` and `cfg_errresp` are registered. A request is judged by the values present at the edge before its acceptance edge.
- R13: For a forwarded transaction, `rsp_err` copies the port's `dn_rerr`. `rsp_rdata` is 0 for a forwarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ns | input | NPORTS | Per-port world: 1 non-secure only, 0 secure only |
| cfg_upriv | input | NPORTS | Per-port permit for unprivileged access |
| cfg_errresp | input | 1 | Refusal answer: 1 error, 0 quiet success |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear and suppress violation status |
| irq | output | 1 | Registered violation interrupt |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate idle, request accepted |
| req_port | input | $clog2(NPORTS) | Target port index |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Address |
| req_size | input | 2 | Size code, log2 of byte count |
| req_wdata | input | DW | Write data, low bytes significant |
| req_secure | input | 1 | Secure-world attribute |
| req_user | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response error |
| rsp_rdata | output | DW | Read data, right-aligned |
| dn_valid | output | NPORTS | One-hot downstream request |
| dn_ready | input | NPORTS | Per-port request acceptance |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | AW | Forwarded address |
| dn_size | output | 2 | Forwarded size code |
| dn_strb | output | DW/8 | Byte-lane enables |
| dn_wdata | output | DW | Lane-placed write data |
| dn_secure | output | 1 | Forwarded secure attribute |
| dn_user | output | 1 | Forwarded unprivileged attribute |
| dn_rvalid | input | NPORTS | Per-port response valid |
| dn_rerr | input | NPORTS | Per-port response error |
| dn_rdata | input | NPORTS*DW | Per-port read data, port i at bits i*DW upward |

## Verification
The bench builds the gate with sixteen ports, a 64-bit data path and `SEC_BYPASS` = 16'h00F0. With these values, exempt ports and checked ports can be reached with the same configuration words. A user access to an exempt port shows that only the world check is skipped. The 8-byte data path makes all four size codes and every aligned lane offset reachable. Requests are issued on the cycle a configuration changes, which exposes the one-cycle configuration lag. The clear input is held across a refusal to show that the refusal is suppressed.

// File: rtl/ppg_gate.sv
module ppg_gate #(
  parameter int NPORTS = 16,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter logic [NPORTS-1:0] SEC_BYPASS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    cfg_ns,
  input  logic [NPORTS-1:0]    cfg_upriv,
  input  logic                 cfg_errresp,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  output logic                 irq,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [$clog2(NPORTS)-1:0] req_port,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic [DW-1:0]        req_wdata,
  input  logic                 req_secure,
  input  logic                 req_user,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NPORTS-1:0]    dn_valid,
  input  logic [NPORTS-1:0]    dn_ready,
  output logic                 dn_write,
  output logic [AW-1:0]        dn_addr,
  output logic [1:0]           dn_size,
  output logic [DW/8-1:0]      dn_strb,
  output logic [DW-1:0]        dn_wdata,
  output logic                 dn_secure,
  output logic                 dn_user,
  input  logic [NPORTS-1:0]    dn_rvalid,
  input  logic [NPORTS-1:0]    dn_rerr,
  input  logic [NPORTS*DW-1:0] dn_rdata
);
  localparam int PW = $clog2(NPORTS);
  localparam int BW = DW / 8;
  localparam int OW = $clog2(BW);

  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_WAIT, ST_LOCAL} st_t;

  st_t st_q;
  logic [NPORTS-1:0] ns_q, up_q;
  logic esel_q, viol_q, irq_q;
  logic [PW-1:0] port_q;
  logic wr_q, sec_q, user_q, err_q;
  logic [AW-1:0] addr_q;
  logic [1:0] size_q;
  logic [DW-1:0] wdata_q;

  logic accept, sec_fail, priv_fail, refuse, viol_nx;
  logic [BW-1:0] lane_m;
  logic [DW-1:0] data_m, rd_sel, rd_sh;
  logic [OW-1:0] off;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign sec_fail  = !SEC_BYPASS[req_port] && (req_secure == ns_q[req_port]);
  assign priv_fail = req_user && !up_q[req_port];
  assign refuse    = sec_fail || priv_fail;
  assign viol_nx   = irq_clr ? 1'b0 : (viol_q || (accept && refuse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      up_q   <= '0;
      esel_q <= 1'b0;
      viol_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ns_q   <= cfg_ns;
      up_q   <= cfg_upriv;
      esel_q <= cfg_errresp;
      viol_q <= viol_nx;
      irq_q  <= viol_nx && irq_en;
    end
  end

  assign irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      port_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      sec_q   <= 1'b0;
      user_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          port_q  <= req_port;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          size_q  <= req_size;
          wdata_q <= req_wdata;
          sec_q   <= req_secure;
          user_q  <= req_user;
          err_q   <= esel_q;
          st_q    <= refuse ? ST_LOCAL : ST_FWD;
        end
        ST_FWD:  if (dn_ready[port_q]) st_q <= ST_WAIT;
        ST_WAIT: if (dn_rvalid[port_q]) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign off    = addr_q[OW-1:0];
  assign lane_m = BW'((32'd1 << (32'd1 << size_q)) - 32'd1);

  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign data_m[i*8 +: 8] = {8{lane_m[i]}};
  end

  assign dn_valid  = (st_q == ST_FWD) ? (NPORTS'(1) << port_q) : '0;
  assign dn_write  = wr_q;
  assign dn_addr   = addr_q;
  assign dn_size   = size_q;
  assign dn_strb   = lane_m << off;
  assign dn_wdata  = wdata_q << {off, 3'b000};
  assign dn_secure = sec_q;
  assign dn_user   = user_q;

  assign rd_sel = dn_rdata[port_q*DW +: DW];
  assign rd_sh  = rd_sel >> {off, 3'b000};

  assign rsp_valid = (st_q == ST_LOCAL) || (st_q == ST_WAIT && dn_rvalid[port_q]);
  assign rsp_err   = (st_q == ST_LOCAL) ? err_q : (rsp_valid && dn_rerr[port_q]);
  assign rsp_rdata = (st_q == ST_WAIT && dn_rvalid[port_q] && !wr_q) ? (rd_sh & data_m) : '0;
endmodule

// File: rtl/ppg_gate_chk.sv
module ppg_gate_chk #(
  parameter int NPORTS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              irq_en,
  input logic              irq_clr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NPORTS-1:0] dn_valid,
  input logic [NPORTS-1:0] dn_ready
);
  // R9
  dn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  // R9
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dn_valid) && !(|(dn_valid & dn_ready))) |=> $stable(dn_valid));

  // R9
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || (|dn_valid)));

  // R8
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

bind ppg_gate ppg_gate_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en), .irq_clr(irq_clr),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .dn_valid(dn_valid), .dn_ready(dn_ready)
);

// File: tb/ppg_gate_test.sv
module ppg_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int BW = DW / 8;
  localparam logic [NP-1:0] MASK = 16'h00F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] cfg_ns = '0, cfg_upriv = '0;
  logic cfg_errresp = 1'b0, irq_en = 1'b0, irq_clr = 1'b0, irq;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_port = '0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_secure = 1'b0, req_user = 1'b0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [NP-1:0] dn_valid;
  logic [NP-1:0] dn_ready, dn_rvalid, dn_rerr;
  logic dn_write, dn_secure, dn_user;
  logic [AW-1:0] dn_addr;
  logic [1:0] dn_size;
  logic [BW-1:0] dn_strb;
  logic [DW-1:0] dn_wdata;
  logic [NP*DW-1:0] dn_rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ppg_gate #(.NPORTS(NP), .AW(AW), .DW(DW), .SEC_BYPASS(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ns(cfg_ns), .cfg_upriv(cfg_upriv),
    .cfg_errresp(cfg_errresp), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_strb(dn_strb), .dn_wdata(dn_wdata),
    .dn_secure(dn_secure), .dn_user(dn_user), .dn_rvalid(dn_rvalid),
    .dn_rerr(dn_rerr), .dn_rdata(dn_rdata)
  );

  // downstream responder: ready one cycle after request, response the next
  int rs = 0, rp = 0;
  logic [AW-1:0] rs_addr;
  always @(posedge clk) begin
    if (!rst_n) begin
      rs <= 0; dn_ready <= '0; dn_rvalid <= '0; dn_rerr <= '0; dn_rdata <= '0; rs_addr <= '0;
    end else begin
      case (rs)
        0: if (|dn_valid) begin
          for (int i = 0; i < NP; i++) if (dn_valid[i]) rp <= i;
          for (int i = 0; i < NP; i++) if (dn_valid[i]) dn_ready[i] <= 1'b1;
          rs_addr <= dn_addr;
          rs <= 1;
        end
        1: begin
          dn_ready <= '0;
          dn_rvalid[rp] <= 1'b1;
          dn_rerr[rp] <= rs_addr[20];
          for (int i = 0; i < NP; i++)
            dn_rdata[i*DW +: DW] <= {8'(i), 8'h5A, 16'hC3E1, rs_addr};
          rs <= 2;
        end
        default: begin
          dn_rvalid <= '0; dn_rerr <= '0; rs <= 0;
        end
      endcase
    end
  end

  // reference model, advanced on every rising edge
  int m_st = 0, m_port = 0, m_size = 0;
  bit m_wr, m_sec, m_user, m_err, m_esel, m_viol, m_irq;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0;
  logic [NP-1:0] m_ns = '0, m_up = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ns = '0; m_up = '0; m_esel = 0; m_viol = 0; m_irq = 0;
    end else begin
      bit ablk, sf, pf;
      ablk = 0;
      case (m_st)
        0: if (req_valid) begin
          m_port = int'(req_port); m_wr = req_write; m_addr = req_addr;
          m_size = int'(req_size); m_wd = req_wdata; m_sec = req_secure; m_user = req_user;
          sf = !MASK[m_port] && (req_secure == m_ns[m_port]);
          pf = req_user && !m_up[m_port];
          ablk = sf || pf;
          m_err = m_esel;
          m_st = ablk ? 3 : 1;
        end
        1: if (dn_ready[m_port]) m_st = 2;
        2: if (dn_rvalid[m_port]) m_st = 0;
        default: m_st = 0;
      endcase
      m_ns = cfg_ns; m_up = cfg_upriv; m_esel = cfg_errresp;
      if (irq_clr) m_viol = 0;
      else if (ablk) m_viol = 1;
      m_irq = m_viol && irq_en;
    end
  end

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP-1:0] edv;
      logic [DW-1:0] erd, ewd, wmask;
      logic [BW-1:0] es;
      bit erv, ere;
      int off;
      off = int'(m_addr[2:0]);
      edv = (m_st == 1) ? (NP'(1) << m_port) : '0;
      erv = (m_st == 3) || (m_st == 2 && dn_rvalid[m_port]);
      ere = erv && ((m_st == 3) ? m_err : dn_rerr[m_port]);
      erd = '0;
      if (m_st == 2 && dn_rvalid[m_port] && !m_wr)
        for (int i = 0; i < (1 << m_size); i++)
          erd[8*i +: 8] = dn_rdata[m_port*DW + 8*(off+i) +: 8];
      chk("req_ready", 128'(req_ready), 128'(m_st == 0));
      chk("dn_valid", 128'(dn_valid), 128'(edv));
      chk("rsp_valid", 128'(rsp_valid), 128'(erv));
      chk("rsp_err", 128'(rsp_err), 128'(ere));
      chk("rsp_rdata", 128'(rsp_rdata), 128'(erd));
      chk("irq", 128'(irq), 128'(m_irq));
      if (m_st == 1) begin
        es = '0; ewd = '0; wmask = '0;
        for (int i = 0; i < (1 << m_size); i++) begin
          es[off+i] = 1'b1;
          ewd[8*(off+i) +: 8] = m_wd[8*i +: 8];
          wmask[8*(off+i) +: 8] = 8'hFF;
        end
        chk("dn_strb", 128'(dn_strb), 128'(es));
        chk("dn_wdata", 128'(dn_wdata & wmask), 128'(ewd));
        chk("dn_addr", 128'(dn_addr), 128'(m_addr));
        chk("dn_size", 128'(dn_size), 128'(m_size));
        chk("dn_attr", 128'({dn_write, dn_secure, dn_user}), 128'({m_wr, m_sec, m_user}));
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  task automatic send(int p, bit wr, logic [AW-1:0] a, int sz, logic [DW-1:0] wd, bit sec, bit usr);
    @(negedge clk);
    req_valid = 1'b1; req_port = 4'(p); req_write = wr; req_addr = a;
    req_size = 2'(sz); req_wdata = wd; req_secure = sec; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    send(2, 0, 32'h100, 3, '0, 1, 0);
    send(2, 0, 32'h108, 3, '0, 1, 1);
    cur_req = "R2";
    send(2, 0, 32'h110, 2, '0, 0, 0);
    cur_req = "R7";
    idle(1); irq_en = 1'b1; idle(3);
    irq_en = 1'b0; idle(2); irq_en = 1'b1; idle(2);
    cur_req = "R8";
    irq_clr = 1'b1; idle(2); irq_clr = 1'b0; idle(2);

    cfg_ns = 16'h0F0F; cfg_upriv = 16'h3333; idle(2);
    cur_req = "R2";
    send(0, 1, 32'h200, 2, 64'h1122_3344, 1, 0);
    send(0, 1, 32'h204, 2, 64'h5566_7788, 0, 0);
    send(8, 0, 32'h208, 3, '0, 0, 0);
    send(12, 0, 32'h210, 3, '0, 0, 0);
    send(12, 0, 32'h218, 3, '0, 1, 0);
    cur_req = "R3";
    send(5, 0, 32'h300, 3, '0, 0, 0);
    send(5, 0, 32'h308, 3, '0, 1, 0);
    send(6, 1, 32'h310, 1, 64'hBEEF, 0, 0);
    cur_req = "R4";
    send(6, 0, 32'h318, 3, '0, 1, 1);
    send(1, 0, 32'h320, 3, '0, 0, 1);
    send(2, 0, 32'h328, 3, '0, 1, 1);

    cur_req = "R8";
    irq_clr = 1'b1; idle(1);
    send(2, 0, 32'h330, 3, '0, 0, 0);
    irq_clr = 1'b0; idle(3);

    cur_req = "R5";
    cfg_errresp = 1'b1; idle(2);
    send(2, 0, 32'h400, 3, '0, 0, 0);
    send(3, 1, 32'h404, 2, 64'hAAAA_BBBB, 0, 1);
    cur_req = "R6";
    cfg_errresp = 1'b0; idle(2);
    send(2, 0, 32'h408, 3, '0, 0, 0);
    send(3, 1, 32'h40C, 2, 64'hCCCC_DDDD, 1, 0);

    cur_req = "R11";
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 8; o += (1 << sz)) begin
        send(9, 0, 32'h500 + 32'(o), sz, '0, 0, 0);
        send(9, 1, 32'h540 + 32'(o), sz, 64'h0807_0605_0403_0201 + 64'(o), 0, 0);
      end

    cur_req = "R13";
    send(4, 0, 32'h0010_0008, 3, '0, 0, 0);
    send(4, 1, 32'h0010_0010, 3, 64'h55, 1, 0);
    send(4, 1, 32'h0000_0018, 3, 64'h66, 1, 0);

    cur_req = "R12";
    @(negedge clk);
    cfg_ns[10] = 1'b0;
    req_valid = 1'b1; req_port = 4'd10; req_write = 1'b0; req_addr = 32'h600;
    req_size = 2'd3; req_secure = 1'b1; req_user = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    cfg_errresp = 1'b1;
    req_valid = 1'b1; req_port = 4'd10; req_secure = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    cfg_errresp = 1'b0;

    cur_req = "R9";
    send(7, 0, 32'h700, 3, '0, 0, 1);
    send(7, 0, 32'h708, 3, '0, 1, 0);
    idle(4);

    cur_req = "R1";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    send(0, 0, 32'h800, 3, '0, 0, 0);
    send(0, 0, 32'h808, 3, '0, 1, 0);
    idle(3);
    finish_up();
  end
endmodule